// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the synchronized input vector of an eight-pin general-purpose port into per-pin interrupt status and a single combined interrupt request. For each pin, software chooses level or edge detection. It also chooses the active polarity. In edge mode it can instead ask for both edges to count.

Level-mode status follows the pin: it is set while the active level is present and drops by itself once the level goes away. Edge-mode status is sticky and is removed only by writing a one to the matching bit of the clear register. A mask register selects which pins take part in the combined request.

Configuration and status are reached through a plain single-cycle write strobe and a combinational read port addressed by a 12-bit byte offset. The pin vector must already be synchronized to `clk`.

Top module: `pin_irq_unit`

## Requirements
- R1: While `rst_n` is low on a clock edge, the sense, both-edge, polarity, mask and raw-status registers become 0, and `irq_out` is 0 in the cycle after.
- R2: Writing offset 0x404 (sense), 0x408 (both-edge), 0x40C (polarity) or 0x410 (mask) stores `reg_wdata` there. A read of the same offset returns it in `reg_rdata[7:0]`, with every higher bit and every unused offset reading 0.
- R3: With sense bit = 1 (level mode), the raw-status bit (read at 0x414) is 1 one cycle after the pin equals its polarity bit (1 = high active, 0 = low active). It is 0 one cycle after the pin leaves that level. A clear write does not change it.
- R4: With sense bit = 0 and both-edge bit = 0, polarity 1 sets the raw bit one cycle after a 0-to-1 change of the pin, and polarity 0 sets it after a 1-to-0 change. The opposite change sets nothing. An edge is a difference between the pin's value and its value on the previous clock.
- R5: With sense bit = 0 and both-edge bit = 1, any change of the pin sets its raw bit, whatever its polarity bit holds.
- R6: In edge mode a set raw bit stays set until a write to offset 0x41C carries 1 in that bit position, and it reads 0 from the next cycle. Zero bits in that write leave their raw bits unchanged.
- R7: If an edge and a clear of the same bit fall in the same cycle, the bit remains set.
- R8: Offset 0x418 reads raw status AND mask. `irq_out` is 1 exactly when that masked value is nonzero.
- R9: Writes to 0x414 and 0x418 change nothing, and a read of 0x41C returns 0.
- R10: While reset is held, the previous-sample register follows the pins, so no edge is seen on the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_sync | input | NP (8) | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | AW (12) | Byte offset for read and write |
| reg_wdata | input | NP (8) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, zero-extended |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight pins, a 12-bit offset and a 32-bit read word. At these values every offset the block decodes can be reached, and the zero upper read bits can be seen. Splitting the pins into rising-active and falling-active halves lets one pin-vector change exercise both polarities at once. The same split lets level and edge mode run side by side with clears landing on chosen bits in the same cycle as edges.

// File: rtl/pirq_pkg.sv
// Shared register offsets for the pin interrupt detector.
// Assumes byte addressing with 12-bit offsets.
package pirq_pkg;
    localparam int unsigned OFF_SENSE  = 32'h404;
    localparam int unsigned OFF_BOTH   = 32'h408;
    localparam int unsigned OFF_POL    = 32'h40C;
    localparam int unsigned OFF_MASK   = 32'h410;
    localparam int unsigned OFF_RAW    = 32'h414;
    localparam int unsigned OFF_MASKED = 32'h418;
    localparam int unsigned OFF_CLEAR  = 32'h41C;
endpackage

// File: rtl/pirq_cfg_regs.sv
// Configuration registers: sense, both-edge, polarity and mask.
// Also turns a write to the clear offset into a one-cycle clear vector.
// Assumes writes are single-cycle strobes; the status offsets are not writable here.
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter int NP = 8,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [NP-1:0] wdata,
    output logic [NP-1:0] sense,
    output logic [NP-1:0] both,
    output logic [NP-1:0] pol,
    output logic [NP-1:0] mask,
    output logic [NP-1:0] clr
);
    // Store configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense <= '0;
            both  <= '0;
            pol   <= '0;
            mask  <= '0;
        end else if (wr) begin
            if (addr == AW'(OFF_SENSE)) sense <= wdata;
            if (addr == AW'(OFF_BOTH))  both  <= wdata;
            if (addr == AW'(OFF_POL))   pol   <= wdata;
            if (addr == AW'(OFF_MASK))  mask  <= wdata;
        end
    end

    // Decode the write-one clear vector for this cycle.
    always_comb begin
        clr = (wr && addr == AW'(OFF_CLEAR)) ? wdata : '0;
    end
endmodule

// File: rtl/pirq_pin_detect.sv
// Per-pin detector: keeps the previous sample and produces the raw status.
// Level-mode bits follow the pin, and edge-mode bits latch until cleared.
// An edge beats a clear in the same cycle.
// Assumes pin inputs are already synchronized to clk.
module pirq_pin_detect #(
    parameter int NP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pin,
    input  logic [NP-1:0] sense,
    input  logic [NP-1:0] both,
    input  logic [NP-1:0] pol,
    input  logic [NP-1:0] clr,
    output logic [NP-1:0] raw
);
    for (genvar g = 0; g < NP; g++) begin : g_pin
        logic prev_q;
        logic raw_q;
        logic hit;

        // Decide whether this cycle carries a qualifying edge.
        always_comb begin
            if (both[g])     hit = pin[g] ^ prev_q;
            else if (pol[g]) hit = pin[g] & ~prev_q;
            else             hit = ~pin[g] & prev_q;
        end

        // Track the previous sample and update the raw status.
        always_ff @(posedge clk) begin
            prev_q <= pin[g];
            if (!rst_n)        raw_q <= 1'b0;
            else if (sense[g]) raw_q <= (pin[g] == pol[g]);
            else               raw_q <= hit | (raw_q & ~clr[g]);
        end

        assign raw[g] = raw_q;
    end
endmodule

// File: rtl/pirq_read_mux.sv
// Read multiplexer: returns the addressed register, zero-extended.
// Unused offsets and the clear offset read 0.
module pirq_read_mux
    import pirq_pkg::*;
#(
    parameter int NP = 8,
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [NP-1:0] sense,
    input  logic [NP-1:0] both,
    input  logic [NP-1:0] pol,
    input  logic [NP-1:0] mask,
    input  logic [NP-1:0] raw,
    input  logic [NP-1:0] masked,
    output logic [DW-1:0] rdata
);
    logic [NP-1:0] sel;

    // Select the register named by the offset.
    always_comb begin
        if      (addr == AW'(OFF_SENSE))  sel = sense;
        else if (addr == AW'(OFF_BOTH))   sel = both;
        else if (addr == AW'(OFF_POL))    sel = pol;
        else if (addr == AW'(OFF_MASK))   sel = mask;
        else if (addr == AW'(OFF_RAW))    sel = raw;
        else if (addr == AW'(OFF_MASKED)) sel = masked;
        else                              sel = '0;
        rdata = DW'(sel);
    end
endmodule

// File: rtl/pin_irq_unit.sv
// Top of the pin interrupt detector.
// Ties the configuration registers, the per-pin detectors and the read port together.
// Forms the masked status and the combined request.
// Assumes DW >= NP and synchronized pins.
module pin_irq_unit #(
    parameter int NP = 8,
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pin_sync,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [NP-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);
    logic [NP-1:0] cfg_sense, cfg_both, cfg_pol, cfg_mask, clr_vec;
    logic [NP-1:0] raw_st, masked_st;

    pirq_cfg_regs #(.NP(NP), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .sense(cfg_sense), .both(cfg_both), .pol(cfg_pol), .mask(cfg_mask), .clr(clr_vec)
    );

    pirq_pin_detect #(.NP(NP)) u_det (
        .clk(clk), .rst_n(rst_n), .pin(pin_sync), .sense(cfg_sense), .both(cfg_both),
        .pol(cfg_pol), .clr(clr_vec), .raw(raw_st)
    );

    // Apply the mask and merge into one request.
    always_comb begin
        masked_st = raw_st & cfg_mask;
        irq_out   = |masked_st;
    end

    pirq_read_mux #(.NP(NP), .AW(AW), .DW(DW)) u_rd (
        .addr(reg_addr), .sense(cfg_sense), .both(cfg_both), .pol(cfg_pol),
        .mask(cfg_mask), .raw(raw_st), .masked(masked_st), .rdata(reg_rdata)
    );
endmodule

// File: rtl/pirq_checker.sv
// Assertion checker for pin_irq_unit, attached with bind below.
module pirq_checker
    import pirq_pkg::*;
#(
    parameter int NP = 8,
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] pin,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input logic          irq,
    input logic [NP-1:0] sense,
    input logic [NP-1:0] pol,
    input logic [NP-1:0] mask,
    input logic [NP-1:0] clr,
    input logic [NP-1:0] raw
);
    // R1: reset empties the status and drops the request.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (raw == '0 && !irq));

    // R3: level-mode bits mirror the active level of the previous cycle.
    a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(sense)) == ($past(sense) & ~($past(pin) ^ $past(pol)))));

    // R6: an edge-mode bit holds unless a clear named it.
    a_r6_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw & ~sense & ~clr) & ~raw) == '0));

    // R8: nothing unmasked can raise the request.
    a_r8_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R9: the clear offset reads back 0.
    a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(OFF_CLEAR)) |-> (rdata == '0));
endmodule

bind pin_irq_unit pirq_checker #(.NP(NP), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin(pin_sync), .addr(reg_addr), .rdata(reg_rdata),
    .irq(irq_out), .sense(cfg_sense), .pol(cfg_pol), .mask(cfg_mask),
    .clr(clr_vec), .raw(raw_st)
);

// File: tb/pin_irq_unit_bench.sv
`timescale 1ns/1ps
module pin_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'h00;
    logic        wr = 1'b0;
    logic [11:0] addr = 12'h000;
    logic [7:0]  wdata = 8'h00;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pin_irq_unit u_pin_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_sync(pins), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
    );

    // Behavioural reference model
    logic [7:0] m_sense, m_both, m_pol, m_mask, m_raw, m_prev, n_raw;
    bit p, q, fire, kill;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sense = 0; m_both = 0; m_pol = 0; m_mask = 0; m_raw = 0;
            m_prev = pins;
        end else begin
            for (int i = 0; i < 8; i++) begin
                p = pins[i];
                q = m_prev[i];
                if (m_sense[i]) begin
                    n_raw[i] = (p == m_pol[i]);
                end else begin
                    if (m_both[i])     fire = (p != q);
                    else if (m_pol[i]) fire = p && !q;
                    else               fire = !p && q;
                    kill = wr && addr == 12'h41C && wdata[i];
                    n_raw[i] = fire || (m_raw[i] && !kill);
                end
            end
            m_raw = n_raw;
            m_prev = pins;
            if (wr) begin
                case (addr)
                    12'h404: m_sense = wdata;
                    12'h408: m_both  = wdata;
                    12'h40C: m_pol   = wdata;
                    12'h410: m_mask  = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(logic [11:0] a);
        case (a)
            12'h404: return {24'h0, m_sense};
            12'h408: return {24'h0, m_both};
            12'h40C: return {24'h0, m_pol};
            12'h410: return {24'h0, m_mask};
            12'h414: return {24'h0, m_raw};
            12'h418: return {24'h0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock; compare against the model at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
        check(cur_req, {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
        check(cur_req, rdata, model_read(addr));
    endtask

    task automatic wreg(logic [11:0] a, logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    // Directed read with a hand-computed expectation.
    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        @(negedge clk);
        repeat (4) step();
        cur_req = "R1";
        check("R1", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        step();
        cur_req = "R10";
        rd("R10", 12'h414, 32'h0);
        rd("R1", 12'h404, 32'h0);
        rd("R1", 12'h410, 32'h0);

        cur_req = "R2";
        wreg(12'h404, 8'hA5); rd("R2", 12'h404, 32'h0000_00A5);
        wreg(12'h408, 8'h3C); rd("R2", 12'h408, 32'h0000_003C);
        wreg(12'h40C, 8'h0F); rd("R2", 12'h40C, 32'h0000_000F);
        wreg(12'h410, 8'hFF); rd("R2", 12'h410, 32'h0000_00FF);
        rd("R2", 12'h400, 32'h0);
        wreg(12'h404, 8'h00);
        wreg(12'h408, 8'h00);
        wreg(12'h41C, 8'hFF);

        cur_req = "R4";
        pins = 8'hFF; step();
        rd("R4", 12'h414, 32'h0F);
        wreg(12'h41C, 8'hFF);
        pins = 8'h00; step();
        rd("R4", 12'h414, 32'hF0);

        cur_req = "R6";
        wreg(12'h41C, 8'h00); rd("R6", 12'h414, 32'hF0);
        wreg(12'h41C, 8'h30); rd("R6", 12'h414, 32'hC0);

        cur_req = "R7";
        pins = 8'h40; step();
        pins = 8'h00;
        wreg(12'h41C, 8'hC0);
        rd("R7", 12'h414, 32'h40);

        cur_req = "R5";
        wreg(12'h408, 8'hFF);
        wreg(12'h41C, 8'hFF);
        pins = 8'h81; step();
        rd("R5", 12'h414, 32'h81);
        wreg(12'h41C, 8'hFF);
        pins = 8'h01; step();
        rd("R5", 12'h414, 32'h80);

        cur_req = "R3";
        wreg(12'h408, 8'h00);
        pins = 8'h00;
        wreg(12'h404, 8'hFF);
        step();
        rd("R3", 12'h414, 32'hF0);
        pins = 8'h0F; step(); rd("R3", 12'h414, 32'hFF);
        pins = 8'hF0; step(); rd("R3", 12'h414, 32'h00);
        pins = 8'h00; step();
        wreg(12'h41C, 8'hFF); rd("R3", 12'h414, 32'hF0);

        cur_req = "R8";
        wreg(12'h410, 8'h00);
        check("R8", {31'h0, irq}, 32'h0);
        wreg(12'h410, 8'h10);
        rd("R8", 12'h418, 32'h10);
        check("R8", {31'h0, irq}, 32'h1);
        pins = 8'h10; step();
        check("R8", {31'h0, irq}, 32'h0);

        cur_req = "R9";
        wreg(12'h414, 8'hFF); rd("R9", 12'h414, 32'hE0);
        wreg(12'h418, 8'hFF); rd("R9", 12'h418, 32'h00);
        rd("R9", 12'h41C, 32'h0);

        repeat (3) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule